// File: doc/BRIEF.md
# Programmable LCD Dot-Clock Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel-request waveforms for a parallel RGB panel. Every timing value is held in a register: the line period in pixel clocks, the frame length in lines, both sync pulse widths, the horizontal and vertical wait counts (measured from the start of the sync pulse to the first active pixel or line), the number of active pixels per line and the number of active lines. Each output has its own polarity select. Two further settings, the sampling edge and a 3-bit output clock-delay code, are only stored and driven onto pins.

Software starts the generator by enabling the sync outputs and then setting the run bit. A frame-buffer base address is double-buffered. The address written to the pending slot reaches the current-base output only at the start of a new frame. To stop cleanly, software clears the dot-clock mode bit. Data enable continues until the frame in progress ends, and then the run bit clears itself. Every writable register can be written directly, or through alias addresses that OR bits in or clear them.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset all registers read 0. hsyncOut, vsyncOut and deOut are 1, because a zero polarity bit selects active-low. pixReq is 0 and curBase is 0.
- R2: With the sync enable set, hsyncOut is active for hsWidth clocks in every line, and active edges are exactly linePeriod clocks apart.
- R3: vsyncOut is active for vsWidth lines in every frame of frameLines lines. Each vsync active edge falls in the same clock as an hsync active edge.
- R4: While run is set, deOut and pixReq are active for activePix clocks per line, starting hWait clocks after the hsync active edge. This happens on the activeLines lines that start vWait lines after the vsync active edge.
- R5: Control bits 3, 4 and 5 make hsync, vsync and data enable active-high when set. Bit 6 drives sampleFalling, and bits 10:8 drive clkDlyCode.
- R6: With control bit 2 (sync enable) clear, every output holds its inactive level. With sync enabled and control bit 0 (run) clear, the sync pulses continue, data enable stays inactive and pixReq stays 0.
- R7: A write addresses register (addr[7:4]) with operation addr[3:2]. The operations are 0 = write, 1 = OR in, and 2 = clear the written bits. Operation 3, or a nonzero addr[1:0], changes nothing.
- R8: A value written to the pending-base register (index 8) appears on curBase and in the read-only register at index 9 only at the next frame start. That is the clock before the vsync active edge becomes visible.
- R9: Clearing control bit 1 (dot-clock mode) while run is set keeps data enable running to the end of the current frame. Run then reads 0 and no further data enable occurs.
- R10: Registers are control (index 0), frameLines (1), vsWidth (2), linePeriod (3), hsWidth (4), waits (5, vWait in bits 31:16 and hWait in bits 11:0), activePix (6), activeLines (7), pending base (8) and current base (9, read-only). Readback is masked to the field widths of 18, 14, 16 and 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Byte address: register index, alias operation, alignment |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| hsyncOut | output | 1 | Horizontal sync, programmable polarity |
| vsyncOut | output | 1 | Vertical sync, programmable polarity |
| deOut | output | 1 | Data enable, programmable polarity |
| pixReq | output | 1 | Active-high pixel request in the data window |
| sampleFalling | output | 1 | Panel samples on the falling clock edge |
| clkDlyCode | output | 3 | Output clock-delay code (2 ns per step) |
| curBase | output | 32 | Frame-buffer base in use for the current frame |

## Verification
A register write takes effect at the clock edge that samples it, and its readback is valid in the following cycle. The timing outputs lag the internal counters by one registered stage. curBase moves one clock before the vsync edge that reports the new frame, so buffer checks are made two cycles after an observed vsync edge. Waveform checks count active cycles and edges over windows that are whole multiples of a frame, and measure gaps relative to observed edges, so the results do not depend on the start phase. All sampling is done on the falling clock edge.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  parameter int CNT_W    = 18;
  parameter int HS_W     = 14;
  parameter int HWAIT_W  = 12;
  parameter int VWAIT_W  = 16;
  parameter int ALINES_W = 16;
  parameter int DLY_W    = 3;
  parameter int DATA_W   = 32;

  localparam int NWR       = 9;
  localparam int RI_CTRL   = 0;
  localparam int RI_FRAME  = 1;
  localparam int RI_VSW    = 2;
  localparam int RI_LINE   = 3;
  localparam int RI_HSW    = 4;
  localparam int RI_WAIT   = 5;
  localparam int RI_APIX   = 6;
  localparam int RI_ALINES = 7;
  localparam int RI_NEXT   = 8;
  localparam int RI_CUR    = 9;
  localparam int VWAIT_LSB = 16;

  localparam int CB_RUN  = 0;
  localparam int CB_DOT  = 1;
  localparam int CB_SYNC = 2;
  localparam int CB_HSP  = 3;
  localparam int CB_VSP  = 4;
  localparam int CB_DEP  = 5;
  localparam int CB_FALL = 6;
  localparam int CB_DLY  = 8;

  typedef struct packed {
    logic [CNT_W-1:0]    linePeriod;
    logic [CNT_W-1:0]    frameLines;
    logic [CNT_W-1:0]    vsWidth;
    logic [CNT_W-1:0]    activePix;
    logic [HS_W-1:0]     hsWidth;
    logic [HWAIT_W-1:0]  hWait;
    logic [VWAIT_W-1:0]  vWait;
    logic [ALINES_W-1:0] activeLines;
  } lcdt_cfg_t;

  typedef struct packed {
    logic genEn;
    logic dataEn;
    logic hsHigh;
    logic vsHigh;
    logic deHigh;
  } lcdt_strb_t;

  function automatic logic [DATA_W-1:0] fieldMask(input int w);
    logic [63:0] full;
    full = (64'd1 << w) - 64'd1;
    return full[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input int idx);
    logic [DATA_W-1:0] m;
    case (idx)
      RI_CTRL:   m = fieldMask(CB_FALL + 1) | (fieldMask(DLY_W) << CB_DLY);
      RI_HSW:    m = fieldMask(HS_W);
      RI_WAIT:   m = (fieldMask(VWAIT_W) << VWAIT_LSB) | fieldMask(HWAIT_W);
      RI_ALINES: m = fieldMask(ALINES_W);
      RI_NEXT:   m = '1;
      default:   m = fieldMask(CNT_W);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              frameStart,
  output lcdt_cfg_t         cfg,
  output lcdt_strb_t        strb,
  output logic              sampleFalling,
  output logic [DLY_W-1:0]  clkDlyCode,
  output logic [DATA_W-1:0] curBase
);

  localparam int IDX_LSB = 4;
  localparam int IDX_W   = ADDR_W - IDX_LSB;

  logic [DATA_W-1:0] regQ [NWR];
  logic [DATA_W-1:0] nxtQ [NWR];
  logic [DATA_W-1:0] curBuf;

  logic [IDX_W-1:0] idx;
  logic [1:0]       op;
  logic             wrOk;
  logic             drainDone;

  assign idx  = busAddr[ADDR_W-1:IDX_LSB];
  assign op   = busAddr[3:2];
  assign wrOk = busWe && (busAddr[1:0] == 2'b00) && (op != 2'd3);

  // run falls by itself once a drain request reaches a frame boundary
  assign drainDone = frameStart && regQ[RI_CTRL][CB_RUN] && !regQ[RI_CTRL][CB_DOT];

  always_comb begin
    for (int i = 0; i < NWR; i++) begin
      logic [DATA_W-1:0] wrVal;
      logic [DATA_W-1:0] hwClr;
      case (op)
        2'd0:    wrVal = busWdata;
        2'd1:    wrVal = regQ[i] | busWdata;
        default: wrVal = regQ[i] & ~busWdata;
      endcase
      hwClr = (i == RI_CTRL && drainDone) ? (DATA_W'(1) << CB_RUN) : '0;
      nxtQ[i] = ((wrOk && int'(idx) == i) ? wrVal : regQ[i]) & ~hwClr & regMask(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NWR; i++) regQ[i] <= '0;
    end else begin
      for (int i = 0; i < NWR; i++) regQ[i] <= nxtQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           curBuf <= '0;
    else if (frameStart) curBuf <= regQ[RI_NEXT];
  end

  always_comb begin
    busRdata = '0;
    if (int'(idx) < NWR)         busRdata = regQ[idx];
    else if (int'(idx) == RI_CUR) busRdata = curBuf;
  end

  assign cfg.linePeriod  = regQ[RI_LINE][CNT_W-1:0];
  assign cfg.frameLines  = regQ[RI_FRAME][CNT_W-1:0];
  assign cfg.vsWidth     = regQ[RI_VSW][CNT_W-1:0];
  assign cfg.activePix   = regQ[RI_APIX][CNT_W-1:0];
  assign cfg.hsWidth     = regQ[RI_HSW][HS_W-1:0];
  assign cfg.hWait       = regQ[RI_WAIT][HWAIT_W-1:0];
  assign cfg.vWait       = regQ[RI_WAIT][VWAIT_LSB+VWAIT_W-1:VWAIT_LSB];
  assign cfg.activeLines = regQ[RI_ALINES][ALINES_W-1:0];

  assign strb.genEn  = regQ[RI_CTRL][CB_SYNC];
  assign strb.dataEn = regQ[RI_CTRL][CB_RUN];
  assign strb.hsHigh = regQ[RI_CTRL][CB_HSP];
  assign strb.vsHigh = regQ[RI_CTRL][CB_VSP];
  assign strb.deHigh = regQ[RI_CTRL][CB_DEP];

  assign sampleFalling = regQ[RI_CTRL][CB_FALL];
  assign clkDlyCode    = regQ[RI_CTRL][CB_DLY+DLY_W-1:CB_DLY];
  assign curBase       = curBuf;

  AST_RUN_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(regQ[RI_CTRL][CB_RUN]) |-> ($past(frameStart) || $past(busWe))); // R9

  AST_BUF_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameStart) |-> (curBase == $past(regQ[RI_NEXT]))); // R8

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frameStart) |-> $stable(curBase)); // R8

endmodule

// File: rtl/lcdt_timing.sv
module lcdt_timing
  import lcdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lcdt_cfg_t  cfg,
  input  lcdt_strb_t strb,
  output logic       frameStart,
  output logic       hsyncOut,
  output logic       vsyncOut,
  output logic       deOut,
  output logic       pixReq
);

  localparam int CW = CNT_W + 1;

  logic [CNT_W-1:0] hCnt, vCnt;
  logic [CW-1:0]    hNext, vNext, hExt, vExt;
  logic             hWrap, vWrap;
  logic             hsAct, vsAct, hWin, vWin, deAct;

  assign hExt  = {1'b0, hCnt};
  assign vExt  = {1'b0, vCnt};
  assign hNext = hExt + CW'(1);
  assign vNext = vExt + CW'(1);
  assign hWrap = hNext >= CW'(cfg.linePeriod);
  assign vWrap = vNext >= CW'(cfg.frameLines);

  assign frameStart = strb.genEn && hWrap && vWrap;

  // both counters restart at the first clock of a sync pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!strb.genEn) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hWrap) begin
      hCnt <= '0;
      vCnt <= vWrap ? '0 : vNext[CNT_W-1:0];
    end else begin
      hCnt <= hNext[CNT_W-1:0];
    end
  end

  assign hsAct = hExt < CW'(cfg.hsWidth);
  assign vsAct = vExt < CW'(cfg.vsWidth);
  assign hWin  = (hExt >= CW'(cfg.hWait)) &&
                 (hExt <  CW'(cfg.hWait) + CW'(cfg.activePix));
  assign vWin  = (vExt >= CW'(cfg.vWait)) &&
                 (vExt <  CW'(cfg.vWait) + CW'(cfg.activeLines));
  assign deAct = strb.genEn && strb.dataEn && hWin && vWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut <= 1'b1;
      vsyncOut <= 1'b1;
      deOut    <= 1'b1;
      pixReq   <= 1'b0;
    end else begin
      hsyncOut <= (strb.genEn && hsAct) ? strb.hsHigh : !strb.hsHigh;
      vsyncOut <= (strb.genEn && vsAct) ? strb.vsHigh : !strb.vsHigh;
      deOut    <= deAct ? strb.deHigh : !strb.deHigh;
      pixReq   <= deAct;
    end
  end

  AST_HS_AT_LINE_START: assert property (@(posedge clk) disable iff (!rstN)
    (strb.genEn && hCnt == '0 && cfg.hsWidth != '0) |=> (hsyncOut == $past(strb.hsHigh))); // R2

  AST_VS_WITH_HS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.genEn && hCnt == '0 && vCnt == '0 && cfg.vsWidth != '0 && cfg.hsWidth != '0)
    |=> ((vsyncOut == $past(strb.vsHigh)) && (hsyncOut == $past(strb.hsHigh)))); // R3

  AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.genEn |=> ((hsyncOut != $past(strb.hsHigh)) && (vsyncOut != $past(strb.vsHigh)))); // R6

  AST_DE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dataEn |=> (!pixReq && (deOut != $past(strb.deHigh)))); // R6

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              pixReq,
  output logic              sampleFalling,
  output logic [DLY_W-1:0]  clkDlyCode,
  output logic [DATA_W-1:0] curBase
);

  lcdt_cfg_t  cfg;
  lcdt_strb_t strb;
  logic       frameStart;

  lcdt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .busWe         (busWe),
    .busAddr       (busAddr),
    .busWdata      (busWdata),
    .busRdata      (busRdata),
    .frameStart    (frameStart),
    .cfg           (cfg),
    .strb          (strb),
    .sampleFalling (sampleFalling),
    .clkDlyCode    (clkDlyCode),
    .curBase       (curBase)
  );

  lcdt_timing u_timing (
    .clk        (clk),
    .rstN       (rstN),
    .cfg        (cfg),
    .strb       (strb),
    .frameStart (frameStart),
    .hsyncOut   (hsyncOut),
    .vsyncOut   (vsyncOut),
    .deOut      (deOut),
    .pixReq     (pixReq)
  );

endmodule

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/1ps
module lcd_timing_gen_test;

  localparam int P = 20, HSW = 3, HW = 6, AP = 10;
  localparam int FL = 12, VSW = 2, VW = 4, AL = 6;
  localparam int FRAME = P * FL;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        hsyncOut, vsyncOut, deOut, pixReq, sampleFalling;
  logic [2:0]  clkDlyCode;
  logic [31:0] curBase;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  logic hsLvl = 1'b1, vsLvl = 1'b1, deLvl = 1'b1;
  int hsAct, vsAct, deAct, prAct, hsRise, vsRise, deRise;
  int hsGapBad, vsMis, deOffBad, firstDeAfterVs;

  always #2 clk = ~clk;

  lcd_timing_gen uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .deOut(deOut), .pixReq(pixReq),
    .sampleFalling(sampleFalling), .clkDlyCode(clkDlyCode), .curBase(curBase)
  );

  task automatic check(input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", what, act, act, exp, exp);
    end
  endtask

  task automatic wr(input int idx, input int op, input logic [31:0] d);
    @(negedge clk);
    busAddr = 8'(idx * 16 + op * 4);
    busWdata = d;
    busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    busAddr = 8'(idx * 16);
    #1 d = busRdata;
  endtask

  task automatic measure(input int n);
    logic pH, pV, pD;
    int sinceHs, sinceVs;
    bit seenHs, seenVs, firstTaken;
    hsAct = 0; vsAct = 0; deAct = 0; prAct = 0;
    hsRise = 0; vsRise = 0; deRise = 0;
    hsGapBad = 0; vsMis = 0; deOffBad = 0; firstDeAfterVs = -1;
    seenHs = 0; seenVs = 0; firstTaken = 0; sinceHs = 0; sinceVs = 0;
    @(negedge clk);
    pH = (hsyncOut == hsLvl); pV = (vsyncOut == vsLvl); pD = (deOut == deLvl);
    for (int c = 0; c < n; c++) begin
      logic h, v, d;
      @(negedge clk);
      h = (hsyncOut == hsLvl); v = (vsyncOut == vsLvl); d = (deOut == deLvl);
      sinceHs++; sinceVs++;
      if (h) hsAct++;
      if (v) vsAct++;
      if (d) deAct++;
      if (pixReq) prAct++;
      if (h && !pH) begin
        hsRise++;
        if (seenHs && sinceHs != P) hsGapBad++;
        seenHs = 1; sinceHs = 0;
      end
      if (v && !pV) begin
        vsRise++;
        if (!(h && !pH)) vsMis++;
        seenVs = 1; sinceVs = 0; firstTaken = 0;
      end
      if (d && !pD) begin
        deRise++;
        if (seenHs && sinceHs != HW) deOffBad++;
        if (seenVs && !firstTaken) begin firstDeAfterVs = sinceVs; firstTaken = 1; end
      end
      pH = h; pV = v; pD = d;
    end
  endtask

  task automatic waitVsRise();
    logic p;
    p = (vsyncOut == vsLvl);
    for (int c = 0; c < 4 * FRAME; c++) begin
      @(negedge clk);
      if ((vsyncOut == vsLvl) && !p) return;
      p = (vsyncOut == vsLvl);
    end
    check(0, 1, "vsync edge seen within four frames");
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(hsyncOut, 1, "R1 hsync idle high after reset");
    check(vsyncOut, 1, "R1 vsync idle high after reset");
    check(deOut, 1, "R1 de idle high after reset");
    check(pixReq, 0, "R1 pixReq low after reset");
    check(curBase, 0, "R1 curBase zero after reset");
    rd(0, d);
    check(d, 0, "R1 control reads zero");
  endtask

  task automatic t_alias();
    logic [31:0] d;
    wr(0, 0, 32'h0);
    wr(0, 1, 32'h40);
    rd(0, d); check(d, 32'h40, "R7 OR alias sets bit");
    check(sampleFalling, 1, "R5 sampleFalling driven from control bit 6");
    wr(0, 1, 32'h500);
    rd(0, d); check(d, 32'h540, "R7 OR alias keeps earlier bits");
    check(clkDlyCode, 5, "R5 clkDlyCode from control bits 10:8");
    wr(0, 2, 32'h40);
    rd(0, d); check(d, 32'h500, "R7 clear alias removes bit");
    wr(0, 3, 32'hFF);
    rd(0, d); check(d, 32'h500, "R7 operation 3 ignored");
    @(negedge clk);
    busAddr = 8'h01; busWdata = 32'h0; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    rd(0, d); check(d, 32'h500, "R7 misaligned write ignored");
    wr(0, 0, 32'h0);
    rd(0, d); check(d, 0, "R7 plain write replaces value");
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(1, 0, 32'hFFFF_FFFF);
    rd(1, d); check(d, 32'h3FFFF, "R10 frameLines masked to 18 bits");
    wr(4, 0, 32'hFFFF_FFFF);
    rd(4, d); check(d, 32'h3FFF, "R10 hsWidth masked to 14 bits");
    wr(5, 0, 32'hFFFF_FFFF);
    rd(5, d); check(d, 32'hFFFF_0FFF, "R10 wait fields at 31:16 and 11:0");
    wr(9, 0, 32'hDEAD_BEEF);
    rd(9, d); check(d, 0, "R10 current base is read-only");
  endtask

  task automatic t_program();
    wr(1, 0, FL);  wr(2, 0, VSW); wr(3, 0, P);  wr(4, 0, HSW);
    wr(5, 0, (VW << 16) | HW);    wr(6, 0, AP); wr(7, 0, AL);
  endtask

  task automatic t_main();
    hsLvl = 1; vsLvl = 1; deLvl = 1;
    wr(0, 0, 32'h3F);
    repeat (30) @(negedge clk);
    measure(2 * FRAME);
    check(hsAct, 2 * FL * HSW, "R2 hsync active clocks over two frames");
    check(hsRise, 2 * FL, "R2 hsync edges over two frames");
    check(hsGapBad, 0, "R2 hsync edge spacing equals line period");
    check(vsAct, 2 * VSW * P, "R3 vsync active clocks over two frames");
    check(vsRise, 2, "R3 one vsync edge per frame");
    check(vsMis, 0, "R3 vsync edge coincides with hsync edge");
    check(deAct, 2 * AP * AL, "R4 de active clocks over two frames");
    check(prAct, 2 * AP * AL, "R4 pixReq active clocks over two frames");
    check(deRise, 2 * AL, "R4 de windows per two frames");
    check(deOffBad, 0, "R4 de starts hWait after hsync edge");
    check(firstDeAfterVs, VW * P + HW, "R4 first de of frame after vsync edge");
  endtask

  task automatic t_polarity();
    hsLvl = 0; vsLvl = 0; deLvl = 0;
    wr(0, 0, 32'h07);
    repeat (5) @(negedge clk);
    measure(FRAME);
    check(hsAct, FL * HSW, "R5 active-low hsync clocks per frame");
    check(vsAct, VSW * P, "R5 active-low vsync clocks per frame");
    check(deAct, AP * AL, "R5 active-low de clocks per frame");
    check(prAct, AP * AL, "R5 pixReq stays active-high");
  endtask

  task automatic t_norun();
    hsLvl = 1; vsLvl = 1; deLvl = 1;
    wr(0, 0, 32'h3E);
    repeat (5) @(negedge clk);
    measure(FRAME);
    check(hsAct, FL * HSW, "R6 hsync continues without run");
    check(vsAct, VSW * P, "R6 vsync continues without run");
    check(deAct, 0, "R6 de inactive without run");
    check(prAct, 0, "R6 pixReq low without run");
    wr(0, 0, 32'h39);
    repeat (5) @(negedge clk);
    measure(FRAME);
    check(hsAct + vsAct + deAct + prAct, 0, "R6 all outputs idle with sync disabled");
  endtask

  task automatic t_buffer();
    wr(0, 0, 32'h3F);
    waitVsRise();
    wr(8, 0, 32'h1234_5600);
    @(negedge clk);
    check(curBase, 0, "R8 pending base not adopted mid-frame");
    waitVsRise();
    @(negedge clk);
    check(curBase, 32'h1234_5600, "R8 pending base adopted at frame start");
  endtask

  task automatic t_drain();
    logic [31:0] d;
    waitVsRise();
    repeat (10) @(negedge clk);
    wr(0, 2, 32'h2);
    rd(0, d); check(d & 1, 1, "R9 run still set right after mode clear");
    measure(2 * FRAME);
    check(deAct, AP * AL, "R9 data enable only for the rest of the frame");
    check(hsAct, 2 * FL * HSW, "R9 sync continues after drain");
    rd(0, d); check(d & 1, 0, "R9 run cleared by itself");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_fields();
    t_program();
    t_main();
    t_polarity();
    t_norun();
    t_buffer();
    t_drain();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule